// File: doc/BRIEF.md
# Pipeline Trap Controller

This block sits beside the hazard logic of a five-stage in-order pipeline and turns exception requests into a redirect of instruction fetch. Two stages can raise a request. The decode stage reports an opcode it does not recognise, and the execute stage reports a signed arithmetic overflow. Each request arrives with the program counter of the instruction that raised it. When a request is taken, the block bubbles the pipeline registers that hold the faulting instruction and every younger one. It stops the faulting instruction from writing the register file or memory, and it hands fetch a handler address in the same cycle.

On the clock edge that ends the redirect cycle, the block stores two values. The saved-PC register gets the faulting instruction's address plus four, and the handler software subtracts four to restart the instruction. The one-bit reason register records why the trap was taken. A mode pin selects the handler entry. With the pin low, every trap enters one shared entry point. With the pin high, the entry point is a per-reason vector spaced 32 bytes apart from a vector base.

Both registers keep their values until the next trap is taken. The pipeline controls of instructions older than the faulting one are passed through unchanged, so those instructions complete.

Top module: `pipe_trap_unit`

## Requirements
- R1: After reset (rst_n low at a clock edge), saved_pc reads 0 and trap_reason reads 0. With no request, fetch_redirect, all three bubble outputs and the write gating are inactive, so ex_reg_we_o follows ex_reg_we_i and ex_mem_we_o follows ex_mem_we_i.
- R2: An execute-stage request (ex_valid=1, ex_overflow=1) takes a trap. At the next rising edge, saved_pc becomes ex_pc+4 and trap_reason becomes 1, where 1 means arithmetic overflow.
- R3: A decode-stage request (id_valid=1, id_bad_op=1) with no execute-stage request takes a trap. At the next rising edge, saved_pc becomes id_pc+4 and trap_reason becomes 0, where 0 means undefined opcode.
- R4: When both stages request in the same cycle, the execute-stage request (the older instruction) is taken and the decode-stage request has no effect on saved_pc or trap_reason.
- R5: With vec_mode=0, a taken trap drives handler_pc to 0x80000180 and asserts fetch_redirect in the same cycle, whatever the reason.
- R6: With vec_mode=1, handler_pc in the redirect cycle is 0xC0000000 + 0x20 × reason. That gives 0xC0000000 for an undefined opcode and 0xC0000020 for an overflow.
- R7: In a cycle where an execute-stage trap is taken, ex_reg_we_o and ex_mem_we_o are 0. In every other cycle they equal ex_reg_we_i and ex_mem_we_i.
- R8: An execute-stage trap asserts bubble_ifid, bubble_idex and bubble_exmem. A decode-stage trap asserts only bubble_ifid and bubble_idex. No trap asserts none of them.
- R9: In a cycle with no taken trap, saved_pc and trap_reason keep their values across the clock edge.
- R10: A request flag whose stage valid bit is 0 is ignored. It produces no redirect, no bubble and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vec_mode | input | 1 | 0: single shared handler entry; 1: per-reason vectors |
| id_valid | input | 1 | Decode stage holds a live instruction |
| id_bad_op | input | 1 | Decode stage found an undefined opcode |
| id_pc | input | 32 | Address of the decode-stage instruction |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_overflow | input | 1 | Execute stage arithmetic overflow |
| ex_pc | input | 32 | Address of the execute-stage instruction |
| ex_reg_we_i | input | 1 | Register-write control leaving execute |
| ex_mem_we_i | input | 1 | Memory-write control leaving execute |
| ex_reg_we_o | output | 1 | Register-write control into EX/MEM, gated |
| ex_mem_we_o | output | 1 | Memory-write control into EX/MEM, gated |
| fetch_redirect | output | 1 | Load handler_pc into the program counter this cycle |
| handler_pc | output | 32 | Handler entry address |
| bubble_ifid | output | 1 | Load a bubble into IF/ID |
| bubble_idex | output | 1 | Load a bubble into ID/EX |
| bubble_exmem | output | 1 | Load a bubble into EX/MEM |
| saved_pc | output | 32 | Faulting address plus four |
| trap_reason | output | 1 | 0 undefined opcode, 1 overflow |

## Verification
The assertions check the following on every cycle:
- the write gating under an execute-stage trap;
- the nesting of the bubble outputs;
- the shared entry address in fixed mode;
- the absence of redirects without a valid request;
- the capture of saved_pc and trap_reason one edge after each kind of trap;
- the hold of both registers when no trap is taken.

Some behaviours need the bench's scenarios. One is the reset values. Another is the vectored address for each reason. A third is that the decode-stage request really loses when both stages request together. The last is that a stream of mixed trap and no-trap cycles leaves the registers holding the right older values. The bench covers these with directed cases and seeded random traffic against its own model.

// File: rtl/trap_pkg.sv
// Shared definitions for the pipeline trap controller.
// Assumes a 32-bit program counter and a one-bit trap reason.
package trap_pkg;
    localparam int PC_W = 32;

    typedef enum logic {
        RSN_BAD_OP   = 1'b0,
        RSN_OVERFLOW = 1'b1
    } trap_reason_e;

    typedef struct packed {
        logic                hit;
        trap_reason_e        reason;
        logic [PC_W-1:0]     pc;
    } trap_pick_t;
endpackage

// File: rtl/trap_arbiter.sv
// Priority picker for trap requests.
// Assumes source index 0 is the oldest instruction; the lowest requesting index wins.
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic                   src_req    [N_SRC],
    input  logic [PC_W-1:0]        src_pc     [N_SRC],
    input  trap_reason_e           src_reason [N_SRC],
    output logic [N_SRC-1:0]       grant,
    output trap_pick_t             pick
);
    // Walk from youngest to oldest so the oldest requester overrides.
    always_comb begin
        grant       = '0;
        pick.hit    = 1'b0;
        pick.reason = RSN_BAD_OP;
        pick.pc     = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (src_req[i]) begin
                grant       = '0;
                grant[i]    = 1'b1;
                pick.hit    = 1'b1;
                pick.reason = src_reason[i];
                pick.pc     = src_pc[i];
            end
        end
    end
endmodule

// File: rtl/trap_vector.sv
// Handler address generator: one shared entry or reason-indexed vectors.
// Assumes vector slots are a power-of-two number of bytes apart.
module trap_vector
    import trap_pkg::*;
#(
    parameter logic [PC_W-1:0] SHARED_ENTRY = 32'h8000_0180,
    parameter logic [PC_W-1:0] VEC_BASE     = 32'hC000_0000,
    parameter int              SLOT_BYTES   = 32
) (
    input  logic            vec_mode,
    input  trap_reason_e    reason,
    output logic [PC_W-1:0] entry
);
    localparam int SLOT_SH = $clog2(SLOT_BYTES);

    logic [PC_W-1:0] slot_off;

    // Select the entry address for the current reason and mode.
    always_comb begin
        slot_off = PC_W'(reason) << SLOT_SH;
        entry    = vec_mode ? (VEC_BASE + slot_off) : SHARED_ENTRY;
    end
endmodule

// File: rtl/trap_regs.sv
// Architectural saved-PC and reason registers.
// Assumes load is high only in a redirect cycle; synchronous active-low reset.
module trap_regs
    import trap_pkg::*;
#(
    parameter int PC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PC_W-1:0] fault_pc,
    input  trap_reason_e    fault_reason,
    output logic [PC_W-1:0] saved_pc,
    output trap_reason_e    saved_reason
);
    // Capture faulting PC plus one instruction and the reason on a taken trap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_pc     <= '0;
            saved_reason <= RSN_BAD_OP;
        end else if (load) begin
            saved_pc     <= fault_pc + PC_W'(PC_STEP);
            saved_reason <= fault_reason;
        end
    end
endmodule

// File: rtl/pipe_trap_unit.sv
// Pipeline trap controller top. It picks the oldest valid request (execute
// before decode), bubbles the faulting and younger stages, gates the faulting
// execute instruction's writes, redirects fetch and records saved PC and reason.
// Assumes the surrounding pipeline applies bubbles and redirect in the same cycle.
module pipe_trap_unit
    import trap_pkg::*;
#(
    parameter logic [31:0] SHARED_ENTRY = 32'h8000_0180,
    parameter logic [31:0] VEC_BASE     = 32'hC000_0000,
    parameter int          SLOT_BYTES   = 32,
    parameter int          PC_STEP      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vec_mode,
    input  logic        id_valid,
    input  logic        id_bad_op,
    input  logic [31:0] id_pc,
    input  logic        ex_valid,
    input  logic        ex_overflow,
    input  logic [31:0] ex_pc,
    input  logic        ex_reg_we_i,
    input  logic        ex_mem_we_i,
    output logic        ex_reg_we_o,
    output logic        ex_mem_we_o,
    output logic        fetch_redirect,
    output logic [31:0] handler_pc,
    output logic        bubble_ifid,
    output logic        bubble_idex,
    output logic        bubble_exmem,
    output logic [31:0] saved_pc,
    output logic        trap_reason
);
    localparam int N_SRC  = 2;
    localparam int SRC_EX = 0;
    localparam int SRC_ID = 1;

    logic            src_req    [N_SRC];
    logic [PC_W-1:0] src_pc     [N_SRC];
    trap_reason_e    src_reason [N_SRC];
    logic [N_SRC-1:0] grant;
    trap_pick_t      pick;
    trap_reason_e    held_reason;

    // Order the sources oldest first for the arbiter.
    always_comb begin
        src_req[SRC_EX]    = ex_valid & ex_overflow;
        src_pc[SRC_EX]     = ex_pc;
        src_reason[SRC_EX] = RSN_OVERFLOW;
        src_req[SRC_ID]    = id_valid & id_bad_op;
        src_pc[SRC_ID]     = id_pc;
        src_reason[SRC_ID] = RSN_BAD_OP;
    end

    trap_arbiter #(.N_SRC(N_SRC)) u_arb (
        .src_req    (src_req),
        .src_pc     (src_pc),
        .src_reason (src_reason),
        .grant      (grant),
        .pick       (pick)
    );

    trap_vector #(
        .SHARED_ENTRY (SHARED_ENTRY),
        .VEC_BASE     (VEC_BASE),
        .SLOT_BYTES   (SLOT_BYTES)
    ) u_vec (
        .vec_mode (vec_mode),
        .reason   (pick.reason),
        .entry    (handler_pc)
    );

    trap_regs #(.PC_STEP(PC_STEP)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (pick.hit),
        .fault_pc     (pick.pc),
        .fault_reason (pick.reason),
        .saved_pc     (saved_pc),
        .saved_reason (held_reason)
    );

    // Bubble the faulting stage and all younger ones; gate faulting writes.
    always_comb begin
        fetch_redirect = pick.hit;
        bubble_ifid    = pick.hit;
        bubble_idex    = pick.hit;
        bubble_exmem   = grant[SRC_EX];
        ex_reg_we_o    = ex_reg_we_i & ~grant[SRC_EX];
        ex_mem_we_o    = ex_mem_we_i & ~grant[SRC_EX];
        trap_reason    = held_reason;
    end
endmodule

// File: rtl/pipe_trap_unit_chk.sv
// Property checker for pipe_trap_unit, attached by bind.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module pipe_trap_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        vec_mode,
    input logic        id_valid,
    input logic        id_bad_op,
    input logic [31:0] id_pc,
    input logic        ex_valid,
    input logic        ex_overflow,
    input logic [31:0] ex_pc,
    input logic        ex_reg_we_o,
    input logic        ex_mem_we_o,
    input logic        fetch_redirect,
    input logic [31:0] handler_pc,
    input logic        bubble_ifid,
    input logic        bubble_idex,
    input logic        bubble_exmem,
    input logic [31:0] saved_pc,
    input logic        trap_reason
);
    AST_OVF_GATES_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_overflow) |-> (!ex_reg_we_o && !ex_mem_we_o)); // R7
    AST_EX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_overflow) |=> (saved_pc == $past(ex_pc) + 32'd4 && trap_reason)); // R2
    AST_ID_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && id_bad_op && !(ex_valid && ex_overflow))
        |=> (saved_pc == $past(id_pc) + 32'd4 && !trap_reason)); // R3
    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_redirect |=> ($stable(saved_pc) && $stable(trap_reason))); // R9
    AST_BUBBLE_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_exmem |-> (bubble_idex && bubble_ifid && fetch_redirect)); // R8
    AST_SHARED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_redirect && !vec_mode) |-> (handler_pc == 32'h8000_0180)); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(id_valid && id_bad_op) && !(ex_valid && ex_overflow))
        |-> (!fetch_redirect && !bubble_ifid && !bubble_idex && !bubble_exmem)); // R10
endmodule

bind pipe_trap_unit pipe_trap_unit_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .vec_mode       (vec_mode),
    .id_valid       (id_valid),
    .id_bad_op      (id_bad_op),
    .id_pc          (id_pc),
    .ex_valid       (ex_valid),
    .ex_overflow    (ex_overflow),
    .ex_pc          (ex_pc),
    .ex_reg_we_o    (ex_reg_we_o),
    .ex_mem_we_o    (ex_mem_we_o),
    .fetch_redirect (fetch_redirect),
    .handler_pc     (handler_pc),
    .bubble_ifid    (bubble_ifid),
    .bubble_idex    (bubble_idex),
    .bubble_exmem   (bubble_exmem),
    .saved_pc       (saved_pc),
    .trap_reason    (trap_reason)
);

// File: tb/test_pipe_trap_unit.sv
// Self-checking bench: directed corner cases plus seeded random traffic.
module test_pipe_trap_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        vec_mode;
    logic        id_valid, id_bad_op, ex_valid, ex_overflow;
    logic [31:0] id_pc, ex_pc;
    logic        ex_reg_we_i, ex_mem_we_i;
    logic        ex_reg_we_o, ex_mem_we_o, fetch_redirect;
    logic [31:0] handler_pc, saved_pc;
    logic        bubble_ifid, bubble_idex, bubble_exmem, trap_reason;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_pc;
    logic        m_rsn;

    always #10 clk = ~clk;

    pipe_trap_unit i_pipe_trap_unit (
        .clk(clk), .rst_n(rst_n), .vec_mode(vec_mode),
        .id_valid(id_valid), .id_bad_op(id_bad_op), .id_pc(id_pc),
        .ex_valid(ex_valid), .ex_overflow(ex_overflow), .ex_pc(ex_pc),
        .ex_reg_we_i(ex_reg_we_i), .ex_mem_we_i(ex_mem_we_i),
        .ex_reg_we_o(ex_reg_we_o), .ex_mem_we_o(ex_mem_we_o),
        .fetch_redirect(fetch_redirect), .handler_pc(handler_pc),
        .bubble_ifid(bubble_ifid), .bubble_idex(bubble_idex),
        .bubble_exmem(bubble_exmem), .saved_pc(saved_pc),
        .trap_reason(trap_reason)
    );

    function automatic logic [31:0] exp_entry(input logic vm, input logic rsn);
        return vm ? (32'hC000_0000 + (rsn ? 32'h20 : 32'h0)) : 32'h8000_0180;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check combinational outputs, then registers after the edge.
    task automatic cycle(input logic vm, input logic iv, input logic ib, input logic [31:0] ip,
                         input logic ev, input logic eo, input logic [31:0] ep,
                         input logic rw, input logic mw);
        logic ex_t, id_t, any_t, r;
        @(negedge clk);
        vec_mode = vm; id_valid = iv; id_bad_op = ib; id_pc = ip;
        ex_valid = ev; ex_overflow = eo; ex_pc = ep; ex_reg_we_i = rw; ex_mem_we_i = mw;
        #1;
        ex_t  = ev & eo;
        id_t  = iv & ib & ~ex_t;
        any_t = ex_t | id_t;
        r     = ex_t;
        chk("R10 redirect", {31'b0, fetch_redirect}, {31'b0, any_t});
        chk("R8 bubble_ifid", {31'b0, bubble_ifid}, {31'b0, any_t});
        chk("R8 bubble_idex", {31'b0, bubble_idex}, {31'b0, any_t});
        chk("R8 bubble_exmem", {31'b0, bubble_exmem}, {31'b0, ex_t});
        chk("R7 reg_we", {31'b0, ex_reg_we_o}, {31'b0, rw & ~ex_t});
        chk("R7 mem_we", {31'b0, ex_mem_we_o}, {31'b0, mw & ~ex_t});
        if (any_t) chk(vm ? "R6 vector entry" : "R5 shared entry", handler_pc, exp_entry(vm, r));
        if (ex_t) begin m_pc = ep + 32'd4; m_rsn = 1'b1; end
        else if (id_t) begin m_pc = ip + 32'd4; m_rsn = 1'b0; end
        @(posedge clk);
        #1;
        chk(ex_t ? "R2/R4 saved_pc" : id_t ? "R3 saved_pc" : "R9 saved_pc hold", saved_pc, m_pc);
        chk(ex_t ? "R2/R4 reason" : id_t ? "R3 reason" : "R9 reason hold",
            {31'b0, trap_reason}, {31'b0, m_rsn});
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1357_9bdf));
        rst_n = 1'b0; vec_mode = 0; id_valid = 0; id_bad_op = 0; id_pc = 0;
        ex_valid = 0; ex_overflow = 0; ex_pc = 0; ex_reg_we_i = 1; ex_mem_we_i = 1;
        repeat (3) @(posedge clk);
        #1;
        m_pc = 32'h0; m_rsn = 1'b0;
        chk("R1 saved_pc reset", saved_pc, 32'h0);
        chk("R1 reason reset", {31'b0, trap_reason}, 32'h0);
        chk("R1 no redirect", {31'b0, fetch_redirect}, 32'h0);
        chk("R1 reg_we pass", {31'b0, ex_reg_we_o}, 32'h1);
        @(negedge clk); rst_n = 1'b1;
        // Directed: each reason in each mode.
        cycle(0, 0, 0, 0, 1, 1, 32'h0000_004C, 1, 0);       // R2 R5
        cycle(0, 0, 0, 0, 0, 0, 0, 1, 1);                   // R9
        cycle(0, 1, 1, 32'h0000_1000, 0, 0, 0, 1, 1);       // R3 R5
        cycle(1, 1, 1, 32'h0000_2000, 0, 0, 0, 0, 0);       // R3 R6
        cycle(1, 0, 0, 0, 1, 1, 32'h0000_3000, 1, 1);       // R2 R6 R7
        // Both at once: execute wins.
        cycle(1, 1, 1, 32'h0000_5000, 1, 1, 32'h0000_4FFC, 1, 1); // R4
        cycle(0, 1, 1, 32'hFFFF_FFFC, 1, 1, 32'h0000_0100, 0, 1); // R4 R7
        // Request flags without valid are ignored.
        cycle(1, 0, 1, 32'h0000_7000, 0, 1, 32'h0000_6000, 1, 1); // R10
        // Top address wraps.
        cycle(0, 1, 1, 32'hFFFF_FFFC, 0, 0, 0, 1, 0);       // R3
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            logic [7:0] k;
            a = $urandom(); b = $urandom(); k = 8'($urandom());
            cycle(k[0], k[1], k[2] & k[7], {a[31:2], 2'b00}, k[3], k[4] & k[6], {b[31:2], 2'b00},
                  k[5], k[6]);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule